// File: doc/BRIEF.md
# Banked Memory Management Unit

This block sits between a CPU with a 16-bit address bus and a 256 KB physical memory. It divides the logical space into four 16 KB areas. Each area can be pointed at any of sixteen 16 KB physical banks. The lower half of the banks is RAM and the upper half is ROM. The block produces the 18-bit physical address, one chip select for the RAM and one for the ROM, and a write strobe that is withheld whenever the target is ROM.

Software programs the map one area at a time. It does this by writing a control byte to an I/O port in a small window of eight port addresses. The byte carries a bank number, the area it applies to, and an active-low enable. When the enable is off, the block falls back to a straight identity map. It still records the area and bank fields, so a complete map can be staged before it is switched on.

Out of reset, area 0 shows a ROM bank so that the CPU can boot. Areas 1 to 3 show RAM.

Top module: `bank_mmu`

## Requirements
- R1: During a memory cycle, `phys_addr[13:0]` equals `cpu_addr[13:0]` and `phys_addr[17:14]` is the bank selected for the area given by `cpu_addr[15:14]`.
- R2: Banks 0 to 7 are RAM and banks 8 to 15 are ROM, so `phys_addr[17]` high selects ROM.
- R3: A control write takes place only on a clock edge where `io_req` and `wr` are both high and `cpu_addr[7:3]` is 5'b00111 (ports 38h to 3Fh). `cpu_addr[15:8]` is ignored. I/O reads, and I/O writes to other ports, leave the map unchanged.
- R4: The control byte is laid out as follows. Bit 3 down to bit 0 is the bank number. Bits 5:4 are the area. Bit 6 has no effect. Bit 7 is the enable, active low. The new mapping applies from the cycle after the write edge.
- R5: After reset the map is: area 0 to bank 15, area 1 to bank 1, area 2 to bank 2, area 3 to bank 3. Translation is enabled.
- R6: `mem_we` is high only when `mem_req` and `wr` are high and the target bank is RAM. A write to a ROM bank leaves both `mem_we` and `ram_cs` low.
- R7: While `mem_req` is high, exactly one of `ram_cs` and `rom_cs` is high.
- R8: While `mem_req` is low, including during I/O cycles, `ram_cs`, `rom_cs` and `mem_we` are low.
- R9: While the enable bit is high, area n translates to bank n. Area and bank fields written in that state are still stored, and they take effect once the enable is cleared.
- R10: The map can be fully reprogrammed after reset. Writing 00h, 11h, 22h and 33h yields an all-RAM map of banks 0 to 3.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| cpu_addr | input | 16 | CPU logical or I/O address |
| cpu_data | input | 8 | CPU write data (control byte) |
| io_req | input | 1 | I/O cycle in progress |
| mem_req | input | 1 | Memory cycle in progress |
| wr | input | 1 | Write strobe |
| phys_addr | output | 18 | Translated physical address |
| ram_cs | output | 1 | RAM chip select |
| rom_cs | output | 1 | ROM chip select |
| mem_we | output | 1 | Memory write strobe, blocked for ROM |

## Verification
The bench builds the block with its default parameters: port window 38h to 3Fh and boot bank 15. With these values the ROM boot map, the mapping of areas into ROM, and the window edges at 37h/40h are all reachable with small literal vectors. Upper I/O address bits are set to nonzero values so that their irrelevance is shown. A staged map under a disabled enable is later switched on, which exposes whether the stored registers survived the identity-mapped interval.

// File: rtl/mmu_pkg.sv
package mmu_pkg;
  localparam int AREA_W = 2;
  localparam int BANK_W = 4;
  localparam int OFFS_W = 14;
  localparam int AREAS  = 1 << AREA_W;
  localparam int PHYS_W = BANK_W + OFFS_W;
  localparam int LOG_W  = AREA_W + OFFS_W;

  typedef logic [BANK_W-1:0] bank_t;
  typedef logic [AREA_W-1:0] area_t;
  typedef logic [OFFS_W-1:0] offs_t;
  typedef logic [PHYS_W-1:0] phys_t;

  // Physical address is the bank placed above the in-area offset.
  function automatic phys_t join_phys(bank_t bank, offs_t offs);
    return {bank, offs};
  endfunction

  // The top bank bit separates ROM (upper half) from RAM (lower half).
  function automatic logic is_rom_bank(bank_t bank);
    return bank[BANK_W-1];
  endfunction

  // Identity bank for an area when translation is switched off.
  function automatic bank_t identity_bank(area_t area);
    return bank_t'(area);
  endfunction
endpackage

// File: rtl/mmu_port_decode.sv
module mmu_port_decode #(
  parameter int          MATCH_LSB = 3,
  parameter int          MATCH_W   = 5,
  parameter logic [MATCH_W-1:0] MATCH_VAL = 5'b00111
) (
  input  logic [MATCH_LSB+MATCH_W-1:0] io_addr,
  input  logic                         io_req,
  input  logic                         wr,
  output logic                         cfg_wr
);
  localparam int TOP = MATCH_LSB + MATCH_W - 1;

  logic port_hit;
  assign port_hit = (io_addr[TOP:MATCH_LSB] == MATCH_VAL);
  assign cfg_wr   = io_req && wr && port_hit;
endmodule

// File: rtl/mmu_map_regs.sv
module mmu_map_regs
  import mmu_pkg::*;
#(
  parameter bank_t BOOT_BANK = 4'hF
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        cfg_wr,
  input  logic                        cfg_off,
  input  area_t                       cfg_area,
  input  bank_t                       cfg_bank,
  output logic [AREAS-1:0][BANK_W-1:0] map_q,
  output logic                        bypass_q
);
  genvar gi;
  generate
    for (gi = 0; gi < AREAS; gi++) begin : g_area
      localparam bank_t RST_BANK = (gi == 0) ? BOOT_BANK : bank_t'(gi);
      logic hit;
      assign hit = cfg_wr && (cfg_area == area_t'(gi));
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)   map_q[gi] <= RST_BANK;
        else if (hit) map_q[gi] <= cfg_bank;
      end
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      bypass_q <= 1'b0;
    else if (cfg_wr) bypass_q <= cfg_off;
  end
endmodule

// File: rtl/mmu_xlate.sv
module mmu_xlate
  import mmu_pkg::*;
(
  input  logic [AREAS-1:0][BANK_W-1:0] map_q,
  input  logic                        bypass,
  input  logic [LOG_W-1:0]            log_addr,
  input  logic                        mem_req,
  input  logic                        wr,
  output phys_t                       phys_addr,
  output logic                        ram_cs,
  output logic                        rom_cs,
  output logic                        mem_we
);
  area_t area;
  bank_t bank;
  logic  to_rom;

  assign area      = log_addr[LOG_W-1:OFFS_W];
  assign bank      = bypass ? identity_bank(area) : map_q[area];
  assign phys_addr = join_phys(bank, log_addr[OFFS_W-1:0]);
  assign to_rom    = is_rom_bank(bank);
  assign ram_cs    = mem_req && !to_rom;
  assign rom_cs    = mem_req && to_rom;
  assign mem_we    = mem_req && wr && !to_rom;
endmodule

// File: rtl/bank_mmu.sv
module bank_mmu
  import mmu_pkg::*;
#(
  parameter logic [4:0] PORT_MATCH = 5'b00111,
  parameter bank_t      BOOT_BANK  = 4'hF
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic [15:0] cpu_addr,
  input  logic [7:0]  cpu_data,
  input  logic        io_req,
  input  logic        mem_req,
  input  logic        wr,
  output logic [17:0] phys_addr,
  output logic        ram_cs,
  output logic        rom_cs,
  output logic        mem_we
);
  // Named internal events, visible to the bound checker.
  logic                         cfg_wr;
  logic                         bypass_q;
  logic [AREAS-1:0][BANK_W-1:0] map_q;

  mmu_port_decode #(
    .MATCH_LSB(3), .MATCH_W(5), .MATCH_VAL(PORT_MATCH)
  ) u_dec (
    .io_addr(cpu_addr[7:0]),
    .io_req (io_req),
    .wr     (wr),
    .cfg_wr (cfg_wr)
  );

  mmu_map_regs #(.BOOT_BANK(BOOT_BANK)) u_regs (
    .clk     (clk),
    .rst_n   (rst_n),
    .cfg_wr  (cfg_wr),
    .cfg_off (cpu_data[7]),
    .cfg_area(cpu_data[5:4]),
    .cfg_bank(cpu_data[3:0]),
    .map_q   (map_q),
    .bypass_q(bypass_q)
  );

  mmu_xlate u_xl (
    .map_q    (map_q),
    .bypass   (bypass_q),
    .log_addr (cpu_addr),
    .mem_req  (mem_req),
    .wr       (wr),
    .phys_addr(phys_addr),
    .ram_cs   (ram_cs),
    .rom_cs   (rom_cs),
    .mem_we   (mem_we)
  );
endmodule

// File: rtl/bank_mmu_chk.sv
module bank_mmu_chk (
  input logic        clk,
  input logic        rst_n,
  input logic [15:0] cpu_addr,
  input logic [7:0]  cpu_data,
  input logic        io_req,
  input logic        mem_req,
  input logic        wr,
  input logic [17:0] phys_addr,
  input logic        ram_cs,
  input logic        rom_cs,
  input logic        mem_we,
  input logic        cfg_wr,
  input logic        bypass_q
);
  // R1: offset bits pass straight through
  a_r1_offset_pass: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req |-> phys_addr[13:0] == cpu_addr[13:0]);

  // R7: exactly one select in a memory cycle
  a_r7_one_select: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req |-> $countones({ram_cs, rom_cs}) == 1);

  // R8: nothing selected outside memory cycles
  a_r8_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    !mem_req |-> !ram_cs && !rom_cs && !mem_we);

  // R6: ROM target never gets a write strobe
  a_r6_rom_write_blocked: assert property (@(posedge clk) disable iff (!rst_n)
    rom_cs |-> !mem_we && !ram_cs);

  // R3: control writes only from I/O write cycles
  a_r3_cfg_needs_io_write: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_wr |-> io_req && wr && !mem_req);

  // R4: enabled write takes effect on the written area from the next cycle
  a_r4_write_applies: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_wr && !cpu_data[7] |=>
      (!(mem_req && cpu_addr[15:14] == $past(cpu_data[5:4])) ||
       phys_addr[17:14] == $past(cpu_data[3:0])));

  // R9: disabled translation is an identity map
  a_r9_bypass_identity: assert property (@(posedge clk) disable iff (!rst_n)
    bypass_q && mem_req |-> phys_addr[17:14] == {2'b00, cpu_addr[15:14]});

  // R4: without a control write the enable state holds
  a_r4_enable_holds: assert property (@(posedge clk) disable iff (!rst_n)
    !cfg_wr |=> $stable(bypass_q));
endmodule

bind bank_mmu bank_mmu_chk u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .cpu_addr (cpu_addr),
  .cpu_data (cpu_data),
  .io_req   (io_req),
  .mem_req  (mem_req),
  .wr       (wr),
  .phys_addr(phys_addr),
  .ram_cs   (ram_cs),
  .rom_cs   (rom_cs),
  .mem_we   (mem_we),
  .cfg_wr   (cfg_wr),
  .bypass_q (bypass_q)
);

// File: tb/tb_bank_mmu.sv
module tb_bank_mmu;
  localparam int CLK_PERIOD = 10;

  typedef struct packed {
    logic        io;
    logic        wr;
    logic [15:0] addr;
    logic [7:0]  data;
    logic [17:0] phys;
    logic        ram;
    logic        rom;
    logic        we;
    logic [3:0]  req;
  } vec_t;

  localparam int NV = 22;
  // io, wr, addr, data, phys, ram, rom, we, req
  localparam vec_t VEC [NV] = '{
    '{1'b0,1'b0,16'h0000,8'h00,18'h3C000,1'b0,1'b1,1'b0,4'd5},  // R5 boot ROM in area 0
    '{1'b0,1'b0,16'h4123,8'h00,18'h04123,1'b1,1'b0,1'b0,4'd5},  // R5 area 1
    '{1'b0,1'b0,16'h8000,8'h00,18'h08000,1'b1,1'b0,1'b0,4'd1},  // R1 area 2
    '{1'b0,1'b0,16'hFFFF,8'h00,18'h0FFFF,1'b1,1'b0,1'b0,4'd1},  // R1 area 3 top
    '{1'b0,1'b1,16'h0010,8'h00,18'h3C010,1'b0,1'b1,1'b0,4'd6},  // R6 write to ROM
    '{1'b1,1'b1,16'h0038,8'h02,18'h00000,1'b0,1'b0,1'b0,4'd8},  // R8 io write, area0<-2
    '{1'b0,1'b0,16'h0005,8'h00,18'h08005,1'b1,1'b0,1'b0,4'd4},  // R4 new map applied
    '{1'b1,1'b1,16'h123F,8'h7A,18'h00000,1'b0,1'b0,1'b0,4'd3},  // R3 high bits, bit6 set
    '{1'b0,1'b1,16'hC100,8'h00,18'h28100,1'b0,1'b1,1'b0,4'd2},  // R2 area3->bank A is ROM
    '{1'b1,1'b1,16'h003A,8'h9F,18'h00000,1'b0,1'b0,1'b0,4'd9},  // R9 disable, stage a1<-F
    '{1'b0,1'b0,16'h0005,8'h00,18'h00005,1'b1,1'b0,1'b0,4'd9},  // R9 identity area 0
    '{1'b0,1'b0,16'hC100,8'h00,18'h0C100,1'b1,1'b0,1'b0,4'd9},  // R9 identity area 3
    '{1'b0,1'b1,16'h4000,8'h00,18'h04000,1'b1,1'b0,1'b1,4'd6},  // R6 RAM write strobe
    '{1'b1,1'b1,16'h0038,8'h00,18'h00000,1'b0,1'b0,1'b0,4'd4},  // R4 enable, area0<-0
    '{1'b0,1'b0,16'h4000,8'h00,18'h3C000,1'b0,1'b1,1'b0,4'd9},  // R9 staged a1 now live
    '{1'b0,1'b0,16'hC100,8'h00,18'h28100,1'b0,1'b1,1'b0,4'd9},  // R9 a3 kept through bypass
    '{1'b1,1'b1,16'h0040,8'h05,18'h00000,1'b0,1'b0,1'b0,4'd3},  // R3 port 40h no match
    '{1'b1,1'b1,16'h0037,8'h05,18'h00000,1'b0,1'b0,1'b0,4'd3},  // R3 port 37h no match
    '{1'b1,1'b0,16'h0038,8'h05,18'h00000,1'b0,1'b0,1'b0,4'd3},  // R3 io read ignored
    '{1'b0,1'b0,16'h0100,8'h00,18'h00100,1'b1,1'b0,1'b0,4'd3},  // R3 area0 still bank 0
    '{1'b1,1'b1,16'hAB3C,8'h21,18'h00000,1'b0,1'b0,1'b0,4'd3},  // R3 area2<-1
    '{1'b0,1'b0,16'h8000,8'h00,18'h04000,1'b1,1'b0,1'b0,4'd7}   // R7 single RAM select
  };

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [15:0] cpu_addr = '0;
  logic [7:0]  cpu_data = '0;
  logic        io_req = 1'b0;
  logic        mem_req = 1'b0;
  logic        wr = 1'b0;
  logic [17:0] phys_addr;
  logic        ram_cs, rom_cs, mem_we;

  int n_chk = 0;
  int n_bad = 0;
  bit done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  bank_mmu dut (
    .clk(clk), .rst_n(rst_n), .cpu_addr(cpu_addr), .cpu_data(cpu_data),
    .io_req(io_req), .mem_req(mem_req), .wr(wr),
    .phys_addr(phys_addr), .ram_cs(ram_cs), .rom_cs(rom_cs), .mem_we(mem_we)
  );

  // Drive on the falling edge, sample 1 time unit later (well before the rising edge).
  task automatic apply(input vec_t v);
    @(negedge clk);
    io_req   = v.io;
    mem_req  = !v.io;
    wr       = v.wr;
    cpu_addr = v.addr;
    cpu_data = v.data;
    #1;
    n_chk++;
    if ((!v.io && phys_addr != v.phys) || ram_cs != v.ram ||
        rom_cs != v.rom || mem_we != v.we) begin
      n_bad++;
      $display("FAIL R%0d addr=%h: got phys=%h ram=%b rom=%b we=%b, expected phys=%h ram=%b rom=%b we=%b",
               v.req, v.addr, phys_addr, ram_cs, rom_cs, mem_we,
               v.phys, v.ram, v.rom, v.we);
    end
  endtask

  function automatic vec_t rd(input logic [15:0] a, input logic [17:0] p,
                              input logic rom, input logic [3:0] r);
    return '{1'b0, 1'b0, a, 8'h00, p, !rom, rom, 1'b0, r};
  endfunction

  function automatic vec_t iow(input logic [7:0] d, input logic [3:0] r);
    return '{1'b1, 1'b1, 16'h0038, d, 18'h0, 1'b0, 1'b0, 1'b0, r};
  endfunction

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  endtask

  initial begin
    #(CLK_PERIOD * 20000);
    n_chk++;
    n_bad++;
    $display("FAIL watchdog: got timeout, expected completion");
    finish_run();
  end

  initial begin
    repeat (3) @(posedge clk);
    // R8: idle outputs during reset
    #1;
    n_chk++;
    if (ram_cs || rom_cs || mem_we) begin
      n_bad++;
      $display("FAIL R8 reset idle: got ram=%b rom=%b we=%b, expected 0 0 0",
               ram_cs, rom_cs, mem_we);
    end
    @(negedge clk);
    rst_n = 1'b1;

    for (int i = 0; i < NV; i++) apply(VEC[i]);

    // R10: reprogram to an all-RAM map
    apply(iow(8'h00, 4'd10));
    apply(iow(8'h11, 4'd10));
    apply(iow(8'h22, 4'd10));
    apply(iow(8'h33, 4'd10));
    apply(rd(16'h0000, 18'h00000, 1'b0, 4'd10));
    apply(rd(16'h7FFF, 18'h07FFF, 1'b0, 4'd10));
    apply(rd(16'hBFFE, 18'h0BFFE, 1'b0, 4'd10));
    apply(rd(16'hC001, 18'h0C001, 1'b0, 4'd10));

    // R5: mid-run reset restores boot map and enable
    apply(iow(8'h85, 4'd5));
    @(negedge clk);
    io_req = 1'b0; mem_req = 1'b0; wr = 1'b0;
    rst_n = 1'b0;
    @(negedge clk);
    rst_n = 1'b1;
    apply(rd(16'h0000, 18'h3C000, 1'b1, 4'd5));
    apply(rd(16'h5000, 18'h05000, 1'b0, 4'd5));
    apply(rd(16'hC000, 18'h0C000, 1'b0, 4'd5));

    // R2: bank 7 is RAM, bank 8 is ROM (boundary)
    apply(iow(8'h17, 4'd2));
    apply(iow(8'h28, 4'd2));
    apply(rd(16'h4000, 18'h1C000, 1'b0, 4'd2));
    apply(rd(16'h8000, 18'h20000, 1'b1, 4'd2));

    @(negedge clk);
    io_req = 1'b0; mem_req = 1'b0; wr = 1'b0;
    finish_run();
  end
endmodule